// File: doc/BRIEF.md
# Reset configuration word fetcher

This block runs once after power-on or hard reset, before the processor core is let go. It walks a boot memory with thirty-two single-byte reads. It collects the bytes into eight 32-bit configuration words. Word 0 belongs to the fetching device. Words 1 to 7 are handed downstream, one per configuration slave. Each read lands on a 64-bit boundary, and only the most significant byte lane of the returned data is used, so the width of the boot port makes no difference.

From its own word the block takes the exception-prefix bit and works out where the core starts fetching. The start address is the system-reset offset 0x100 above either address zero or the high base 0xFFF00000. The core stays held in reset until every read has completed.

The control is a four-state machine:

- **BOOT** is a single idle cycle after reset; it always moves to FETCH.
- **FETCH** keeps the read request raised and moves on to the next address after each accepted read.
- After the last accepted read, FETCH moves to **SETTLE**, which lasts one cycle.
- SETTLE always moves to **READY**, where the block stays until the next reset.

Top module: `cfgword_fetch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_req` is 0, `rd_addr` is 0, `done` is 0, `core_hold` is 1 and `slave_valid` is 0.
- R2: Exactly 32 reads are accepted, where a read is accepted in a cycle with `rd_req` and `rd_ready` both high. Read n (counting from 0) uses byte address 8·n. After the 32nd read `rd_req` stays low.
- R3: While `rd_ready` is low, `rd_req` stays high and `rd_addr` keeps its value.
- R4: Only `rd_data[63:56]` is used. The values on `rd_data[55:0]` have no effect on any output.
- R5: Reads 4k to 4k+3 form word k, with read 4k in bits 31:24 and read 4k+3 in bits 7:0. `own_word` holds word 0.
- R6: For k = 1 to 7, in the cycle after read 4k+3 is accepted, `slave_valid` is high for exactly one cycle, with `slave_idx` = k and `slave_word` = word k. The pulses come in increasing k order, seven in all.
- R7: `prefix` equals bit PREFIX_BIT of `own_word` (default: bit 0). `reset_vector` is 0x00000100 when `prefix` is 0 and 0xFFF00100 when `prefix` is 1.
- R8: `done` rises in the second cycle after the cycle in which the 32nd read is accepted. It then stays high until reset. `core_hold` is the inverse of `done`.
- R9: A reset asserted in the middle of the sequence returns `rd_addr` to 0 at once. After reset is released, the full sequence starts again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | output | ADDR_W (32) | Byte address of the current read |
| rd_req | output | 1 | Read request, held until accepted |
| rd_ready | input | 1 | Boot memory has data for `rd_addr` |
| rd_data | input | DATA_W (64) | Read data; only the top byte lane is used |
| own_word | output | 32 | The fetcher's own configuration word |
| slave_word | output | 32 | Configuration word for a downstream slave |
| slave_valid | output | 1 | One-cycle strobe marking `slave_word` |
| slave_idx | output | IDX_W (3) | Slave number 1 to 7 for `slave_word` |
| prefix | output | 1 | Initial exception-prefix bit |
| reset_vector | output | 32 | Address of the first instruction fetch |
| done | output | 1 | All words have been fetched |
| core_hold | output | 1 | Keeps the core in reset until done |

## Verification
Two events can fall in the same cycle: the one-cycle `slave_valid` pulse for a finished word, and the accepted read that brings in the first byte of the next word. The bench brings this about by holding `rd_ready` high throughout a zero-wait pass. In that pass, each slave pulse lines up with the next read's handshake. Each pulsed word is compared with the word computed from the bench's memory pattern. A byte shifting in during the same cycle must not corrupt the word on offer, and must not move or drop the pulse. Passes with wait states separate the two events, so a fault that only shows up when they overlap is told apart from a packing fault.

// File: rtl/cfgword_fetch_pkg.sv
package cfgword_fetch_pkg;

    // Sequencer states of the fetcher
    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_READY  = 2'd3
    } fetch_state_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned LANE_W     = 8;
    localparam int unsigned CFG_W      = WORD_BYTES * LANE_W;

endpackage

// File: rtl/cfg_read_seq.sv
// Read counter and address stepper: one step per accepted read.
module cfg_read_seq #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned STRIDE    = 8,
    parameter int unsigned NUM_READS = 32,
    localparam int unsigned CNT_W    = $clog2(NUM_READS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  read_idx,
    output logic              last_read
);

    localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(NUM_READS - 1);
    localparam logic [ADDR_W-1:0] STEP_SZ  = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
        end else if (step && (idx_q != LAST_IDX)) begin
            addr_q <= addr_q + STEP_SZ;
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign rd_addr   = addr_q;
    assign read_idx  = idx_q;
    assign last_read = (idx_q == LAST_IDX);

endmodule

// File: rtl/cfg_word_pack.sv
// Packs accepted bytes most-significant-first and routes finished words.
module cfg_word_pack
    import cfgword_fetch_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
    localparam int unsigned CNT_W    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [LANE_W-1:0] lane_byte,
    input  logic [CNT_W-1:0]  read_idx,
    output logic [CFG_W-1:0]  own_word,
    output logic [CFG_W-1:0]  slave_word,
    output logic              slave_valid,
    output logic [IDX_W-1:0]  slave_idx
);

    localparam int unsigned PART_W = CFG_W - LANE_W;

    logic [PART_W-1:0] partial_q;
    logic [CFG_W-1:0]  full_word;
    logic [1:0]        byte_sel;
    logic [IDX_W-1:0]  word_sel;
    logic              word_end;

    logic [CFG_W-1:0]  own_q;
    logic [CFG_W-1:0]  slv_q;
    logic              slv_vld_q;
    logic [IDX_W-1:0]  slv_idx_q;

    assign byte_sel  = read_idx[1:0];
    assign word_sel  = read_idx[CNT_W-1:2];
    assign full_word = {partial_q, lane_byte};
    assign word_end  = step && (byte_sel == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            partial_q <= '0;
        end else if (step) begin
            partial_q <= {partial_q[PART_W-LANE_W-1:0], lane_byte};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q     <= '0;
            slv_q     <= '0;
            slv_vld_q <= 1'b0;
            slv_idx_q <= '0;
        end else begin
            slv_vld_q <= 1'b0;
            if (word_end) begin
                if (word_sel == '0) begin
                    own_q <= full_word;
                end else begin
                    slv_q     <= full_word;
                    slv_vld_q <= 1'b1;
                    slv_idx_q <= word_sel;
                end
            end
        end
    end

    assign own_word    = own_q;
    assign slave_word  = slv_q;
    assign slave_valid = slv_vld_q;
    assign slave_idx   = slv_idx_q;

endmodule

// File: rtl/cfg_vector_sel.sv
// Derives the exception-prefix bit and the first fetch address.
module cfg_vector_sel
    import cfgword_fetch_pkg::*;
#(
    parameter int unsigned PREFIX_BIT = 0,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0100,
    parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000
) (
    input  logic [CFG_W-1:0] own_word,
    output logic             prefix,
    output logic [31:0]      reset_vector
);

    localparam logic [31:0] LOW_VEC  = VEC_OFFSET;
    localparam logic [31:0] HIGH_VEC = HIGH_BASE + VEC_OFFSET;

    assign prefix       = own_word[PREFIX_BIT];
    assign reset_vector = prefix ? HIGH_VEC : LOW_VEC;

endmodule

// File: rtl/cfgword_fetch.sv
module cfgword_fetch
    import cfgword_fetch_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned NUM_WORDS  = 8,
    parameter int unsigned STRIDE     = 8,
    parameter int unsigned PREFIX_BIT = 0,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0100,
    parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
    localparam int unsigned NUM_READS = NUM_WORDS * WORD_BYTES,
    localparam int unsigned CNT_W     = $clog2(NUM_READS),
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_req,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic [CFG_W-1:0]  own_word,
    output logic [CFG_W-1:0]  slave_word,
    output logic              slave_valid,
    output logic [IDX_W-1:0]  slave_idx,
    output logic              prefix,
    output logic [31:0]       reset_vector,
    output logic              done,
    output logic              core_hold
);

    fetch_state_e state_q, state_d;

    logic              step;
    logic              last_read;
    logic [CNT_W-1:0]  read_idx;
    logic [LANE_W-1:0] lane_byte;
    logic              unused_lanes;

    // Only the most significant byte lane carries configuration data
    assign lane_byte    = rd_data[DATA_W-1 -: LANE_W];
    assign unused_lanes = ^rd_data[DATA_W-LANE_W-1:0];
    assign step         = rd_req && rd_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_FETCH;
            ST_FETCH:  if (step && last_read) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_READY;
            ST_READY:  state_d = ST_READY;
            default:   state_d = ST_BOOT;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        rd_req    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_FETCH: rd_req = 1'b1;
            ST_READY: done   = 1'b1;
            default:  ;
        endcase
        core_hold = !done;
    end

    cfg_read_seq #(
        .ADDR_W    (ADDR_W),
        .STRIDE    (STRIDE),
        .NUM_READS (NUM_READS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .rd_addr   (rd_addr),
        .read_idx  (read_idx),
        .last_read (last_read)
    );

    cfg_word_pack #(
        .NUM_WORDS (NUM_WORDS)
    ) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .lane_byte   (lane_byte),
        .read_idx    (read_idx),
        .own_word    (own_word),
        .slave_word  (slave_word),
        .slave_valid (slave_valid),
        .slave_idx   (slave_idx)
    );

    cfg_vector_sel #(
        .PREFIX_BIT (PREFIX_BIT),
        .VEC_OFFSET (VEC_OFFSET),
        .HIGH_BASE  (HIGH_BASE)
    ) u_vec (
        .own_word     (own_word),
        .prefix       (prefix),
        .reset_vector (reset_vector)
    );

endmodule

// File: rtl/cfgword_fetch_chk.sv
module cfgword_fetch_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NUM_WORDS  = 8,
    parameter int unsigned STRIDE     = 8,
    parameter int unsigned PREFIX_BIT = 0,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0100,
    parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
    localparam int unsigned NUM_READS = NUM_WORDS * 4,
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS),
    localparam int unsigned HCNT_W    = $clog2(NUM_READS) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_req,
    input logic              rd_ready,
    input logic [31:0]       own_word,
    input logic              slave_valid,
    input logic [IDX_W-1:0]  slave_idx,
    input logic [31:0]       reset_vector,
    input logic              done
);

    localparam logic [HCNT_W-1:0] ALL_READS = HCNT_W'(NUM_READS);

    logic [HCNT_W-1:0] hs_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cnt <= '0;
        end else if (rd_req && rd_ready) begin
            hs_cnt <= hs_cnt + 1'b1;
        end
    end

    p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hs_cnt == '0) |-> (rd_addr == '0));

    p_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready && hs_cnt != ALL_READS - 1'b1)
        |=> (rd_addr == $past(rd_addr) + ADDR_W'(STRIDE)));

    p_no_extra_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_cnt == ALL_READS) |-> !rd_req);

    p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slave_valid |=> !slave_valid);

    p_slave_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slave_valid |-> (slave_idx != '0));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_done_after_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hs_cnt == ALL_READS));

    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (reset_vector ==
                  (own_word[PREFIX_BIT] ? HIGH_BASE + VEC_OFFSET : VEC_OFFSET)));

endmodule

bind cfgword_fetch cfgword_fetch_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_WORDS  (NUM_WORDS),
    .STRIDE     (STRIDE),
    .PREFIX_BIT (PREFIX_BIT),
    .VEC_OFFSET (VEC_OFFSET),
    .HIGH_BASE  (HIGH_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_addr      (rd_addr),
    .rd_req       (rd_req),
    .rd_ready     (rd_ready),
    .own_word     (own_word),
    .slave_valid  (slave_valid),
    .slave_idx    (slave_idx),
    .reset_vector (reset_vector),
    .done         (done)
);

// File: tb/cfgword_fetch_bench.sv
`timescale 1ns/1ps
module cfgword_fetch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rd_addr;
    logic        rd_req;
    logic        rd_ready = 1'b0;
    logic [63:0] rd_data = '0;
    logic [31:0] own_word;
    logic [31:0] slave_word;
    logic        slave_valid;
    logic [2:0]  slave_idx;
    logic        prefix;
    logic [31:0] reset_vector;
    logic        done;
    logic        core_hold;

    always #2 clk = ~clk;

    cfgword_fetch u_cfgword_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_addr      (rd_addr),
        .rd_req       (rd_req),
        .rd_ready     (rd_ready),
        .rd_data      (rd_data),
        .own_word     (own_word),
        .slave_word   (slave_word),
        .slave_valid  (slave_valid),
        .slave_idx    (slave_idx),
        .prefix       (prefix),
        .reset_vector (reset_vector),
        .done         (done),
        .core_hold    (core_hold)
    );

    // {seed, wait states, lower-lane fill}
    localparam logic [43:0] VECS [5] = '{
        {32'hA5C3_0F10, 4'd0, 8'h00},
        {32'h1234_5679, 4'd2, 8'hFF},
        {32'hFFFF_FFFF, 4'd0, 8'h5A},
        {32'h0000_0000, 4'd5, 8'hFF},
        {32'h8001_00FE, 4'd1, 8'hC3}
    };

    int total = 0;
    int bad   = 0;

    logic [31:0] cur_seed = '0;
    int          cur_wait = 0;
    logic [7:0]  cur_fill = '0;
    bit          mon_en   = 1'b0;

    int          hs_cnt, slv_cnt, since_hs, prev_hs_n;
    bit          prev_hs, prev_wait, done_seen;
    logic [31:0] prev_addr;

    function automatic logic [31:0] exp_word(input logic [31:0] s, input int k);
        return s + 32'(k) * 32'h2468_ACE1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Boot memory model: byte of word n/4 in the top lane, filler below
    initial begin
        int          wcnt;
        logic [31:0] last;
        int          n;
        logic [31:0] w;
        wcnt = 0;
        last = 32'hFFFF_FFFF;
        forever begin
            @(negedge clk);
            n = int'(rd_addr / 8);
            w = exp_word(cur_seed, n / 4);
            rd_data <= {8'(w >> (24 - 8 * (n % 4))),
                        {7{cur_fill ^ rd_addr[7:0]}}};
            if (!rd_req || !rst_n) begin
                rd_ready <= 1'b0;
                wcnt = 0;
                last = 32'hFFFF_FFFF;
            end else begin
                if (rd_addr != last) wcnt = 0;
                last = rd_addr;
                rd_ready <= (wcnt >= cur_wait);
                wcnt++;
            end
        end
    end

    // Monitor, sampling 1 ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && mon_en) begin
                since_hs++;
                if (prev_wait)
                    chk(rd_req && rd_addr == prev_addr, "R3", "request held",
                        rd_addr, prev_addr);
                if (slave_valid) begin
                    chk(slave_idx == 3'(slv_cnt + 1), "R6", "slave index",
                        32'(slave_idx), 32'(slv_cnt + 1));
                    chk(slave_word == exp_word(cur_seed, slv_cnt + 1), "R6",
                        "slave word", slave_word, exp_word(cur_seed, slv_cnt + 1));
                    chk(prev_hs && prev_hs_n == 4 * (slv_cnt + 1) + 3, "R6",
                        "pulse timing", 32'(prev_hs_n), 32'(4 * (slv_cnt + 1) + 3));
                    slv_cnt++;
                end
                if (done && !done_seen) begin
                    done_seen = 1'b1;
                    chk(since_hs == 2, "R8", "done latency", 32'(since_hs), 32'd2);
                end
                prev_hs = 1'b0;
                if (rd_req && rd_ready) begin
                    chk(rd_addr == 32'(hs_cnt * 8), "R2", "read address",
                        rd_addr, 32'(hs_cnt * 8));
                    prev_hs   = 1'b1;
                    prev_hs_n = hs_cnt;
                    hs_cnt++;
                    since_hs  = 0;
                end
                prev_wait = rd_req && !rd_ready;
                prev_addr = rd_addr;
            end
        end
    end

    task automatic clear_mon();
        hs_cnt = 0; slv_cnt = 0; since_hs = 0; prev_hs_n = -1;
        prev_hs = 1'b0; prev_wait = 1'b0; done_seen = 1'b0; prev_addr = '0;
    endtask

    task automatic run_pass(input logic [31:0] seed, input int waitn,
                            input logic [7:0] fill);
        logic [31:0] exp_vec;
        int          cyc;
        mon_en = 1'b0;
        @(negedge clk);
        rst_n    = 1'b0;
        cur_seed = seed;
        cur_wait = waitn;
        cur_fill = fill;
        @(negedge clk);
        #1;
        // R1: state while reset is held
        chk(!rd_req && rd_addr == 0 && !done && core_hold && !slave_valid,
            "R1", "reset outputs", {rd_req, done, core_hold, slave_valid}, 32'h2);
        clear_mon();
        mon_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!rd_req && rd_addr == 0 && core_hold, "R1", "first cycle",
            {31'd0, rd_req}, 32'd0);
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        chk(done == 1'b1, "R8", "done reached", 32'(done), 32'd1);
        repeat (8) @(negedge clk);
        #1;
        exp_vec = seed[0] ? 32'hFFF0_0100 : 32'h0000_0100;
        chk(hs_cnt == 32, "R2", "read count", 32'(hs_cnt), 32'd32);
        chk(slv_cnt == 7, "R6", "slave pulses", 32'(slv_cnt), 32'd7);
        chk(own_word == seed, "R5", "own word", own_word, seed);
        chk(prefix == seed[0], "R7", "prefix", 32'(prefix), 32'(seed[0]));
        chk(reset_vector == exp_vec, "R7", "reset vector", reset_vector, exp_vec);
        chk(done && !core_hold, "R8", "done held", {done, core_hold}, 32'h2);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mon();
        // Table-driven passes: patterns, wait states, lower-lane fill
        for (int i = 0; i < 5; i++) begin
            run_pass(VECS[i][43:12], int'(VECS[i][11:8]), VECS[i][7:0]);
        end

        // R4: same seed as the first entry, different filler and waits
        run_pass(32'hA5C3_0F10, 3, 8'hA5);
        chk(own_word == 32'hA5C3_0F10, "R4", "lower lanes ignored",
            own_word, 32'hA5C3_0F10);

        // R9: reset in the middle of the sequence
        mon_en = 1'b0;
        @(negedge clk);
        rst_n    = 1'b0;
        cur_seed = 32'h5EED_0001;
        cur_wait = 0;
        cur_fill = 8'h3C;
        @(negedge clk);
        rst_n = 1'b1;
        while (rd_addr < 32'd80) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(rd_addr == 0 && !rd_req, "R9", "mid-sequence reset", rd_addr, 32'd0);
        run_pass(32'h5EED_0001, 1, 8'h3C);
        chk(hs_cnt == 32, "R9", "full restart", 32'(hs_cnt), 32'd32);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule